// File: doc/BRIEF.md
# USB Host Controller SMI Event Register

This block is a 32-bit status and enable register that sits beside a USB host controller. It watches the controller's live state lines and records chosen state changes as sticky event flags. Each flag has its own enable bit, and whenever a flag and its enable are both set, the block raises a system management interrupt request. Firmware reads the register to find the cause. It writes a one to a flag to clear it and writes the enable bits as plain read/write data.

Two kinds of event are detected. The periodic schedule enable and the configure flag log a change in either direction. The halted indication logs only a halt that happens while run/stop is low. A rising edge of the controller-reset line also logs an event. Asynchronous advance, power-management change and per-port ownership change arrive as event pulses. The register is reset only by its own suspend-well reset. A reset of the controller is just another event to it and leaves the contents alone.

Top module: `usb_smi_evt_reg`

## Requirements
- R1: While `rst_n` is low at a clock edge, all register bits and `smi_o` become 0.
- R2: Any change of `per_sched_en_i`, rising or falling, sets status bit 18. The matching enable is bit 2.
- R3: Any change of `cfg_flag_i`, rising or falling, sets status bit 19. The matching enable is bit 3.
- R4: A rise of `hc_halted_i` sets status bit 16 only when `run_stop_i` is 0 in that cycle. A rise while `run_stop_i` is 1 sets nothing. The matching enable is bit 0.
- R5: A rise of `hc_reset_i` sets status bit 17 (enable bit 1). Holding the line high does not set the bit again, and asserting it leaves every register bit other than bit 17 unchanged.
- R6: A high `async_evt_i` sets bit 20 (enable bit 4). A high `pm_chg_evt_i` sets bit 21 (enable bit 5). A high `port_own_chg_i[p]` sets bit 22+p (enable bit 6+p).
- R7: A write sets the enable bits [NUM_PORTS+5:0] to the written data. On status bits, writing 1 clears the bit and writing 0 leaves it unchanged.
- R8: When a hardware set and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up 1.
- R9: Bits 15:NUM_PORTS+6 and 31:NUM_PORTS+22 always read 0, whatever is written.
- R10: `smi_o` is registered. In the cycle after any status bit i+16 and enable bit i are both 1, it is 1. Otherwise it is 0 in the following cycle.
- R11: In the first clock cycle after reset is released, the levels on the monitored lines are captured as a baseline and log no change event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Suspend-well synchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_data_o | output | 32 | Register read data |
| per_sched_en_i | input | 1 | Periodic schedule enable level |
| cfg_flag_i | input | 1 | Configure flag level |
| hc_halted_i | input | 1 | Controller halted level |
| run_stop_i | input | 1 | Run/stop level |
| hc_reset_i | input | 1 | Controller reset level |
| async_evt_i | input | 1 | Asynchronous advance event pulse |
| pm_chg_evt_i | input | 1 | Power-management change event pulse |
| port_own_chg_i | input | NUM_PORTS | Per-port ownership change pulses |
| smi_o | output | 1 | SMI request level |

## Verification
The bench toggles the schedule and configure flags in both directions. A detector that saw only rising edges would miss the falls. It raises halted once with run/stop high and once with run/stop low, so a design that ignored the cause would log a spurious halt. It releases reset with monitored lines already high, which catches a detector that treats the reset value as history, and it holds the controller-reset line high across a clear, which catches level rather than edge capture. It also collides a set with a clear on the same bit, writes ones into reserved space, and times the SMI level against enable changes. Any of these would expose a lost event, a nonzero reserved read or an interrupt that is off by a cycle.

// File: rtl/usb_smi_pkg.sv
// Package: shared layout constants for the SMI event register.
// Event index i has its status flag at bit STAT_OFS+i and its enable at bit i.
package usb_smi_pkg;
    localparam int unsigned REG_W    = 32;
    localparam int unsigned STAT_OFS = 16;
    localparam int unsigned EV_HALT  = 0;
    localparam int unsigned EV_HCRST = 1;
    localparam int unsigned EV_PER   = 2;
    localparam int unsigned EV_CF    = 3;
    localparam int unsigned EV_ASYNC = 4;
    localparam int unsigned EV_PM    = 5;
    localparam int unsigned EV_PORT0 = 6;
    // Index of each monitored level inside the edge detector vector.
    localparam int unsigned MON_PER  = 0;
    localparam int unsigned MON_CF   = 1;
    localparam int unsigned MON_HALT = 2;
    localparam int unsigned MON_RST  = 3;
    localparam int unsigned MON_W    = 4;
endpackage

// File: rtl/usb_smi_edge_det.sv
// Module: usb_smi_edge_det
// Keeps a registered copy of W monitored levels and reports per-bit changes
// and rising edges. The first cycle after reset only loads the baseline, so
// lines that are already high at reset release produce no event.
// Assumes inputs are synchronous to clk.
module usb_smi_edge_det #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] chg_o,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;
    logic         primed_q;

    // Capture the last sampled levels and mark the baseline as valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else begin
            prev_q   <= sig_i;
            primed_q <= 1'b1;
        end
    end

    // Compare present against previous levels once a baseline exists.
    always_comb begin
        chg_o  = '0;
        rise_o = '0;
        if (primed_q) begin
            chg_o  = sig_i ^ prev_q;
            rise_o = sig_i & ~prev_q;
        end
    end

    AST_PRIMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |=> primed_q); // R11
    AST_RISE_IS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_o & ~chg_o) == '0)); // R5
endmodule

// File: rtl/usb_smi_evt_bank.sv
// Module: usb_smi_evt_bank
// N sticky status flags. A hardware set raises a flag; a clear request
// lowers it; a set in the same cycle as a clear wins.
// Assumes set_i and clr_i are single-cycle qualified requests.
module usb_smi_evt_bank #(
    parameter int unsigned N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] st_o
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic flag_q;

        // Sticky flag with set priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (set_i[i]) begin
                flag_q <= 1'b1;
            end else if (clr_i[i]) begin
                flag_q <= 1'b0;
            end
        end

        assign st_o[i] = flag_q;

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q && !clr_i[i]) |=> flag_q); // R7
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_q); // R8
    end
endmodule

// File: rtl/usb_smi_irq.sv
// Module: usb_smi_irq
// Registers the OR of status flags masked by their enables into one SMI level.
// Assumes st_i and en_i are aligned bit for bit.
module usb_smi_irq #(
    parameter int unsigned N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] st_i,
    input  logic [N-1:0] en_i,
    output logic         smi_o
);
    logic pending;
    logic smi_q;

    // Any enabled status flag requests an SMI.
    always_comb pending = |(st_i & en_i);

    // Register the request so the output is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) smi_q <= 1'b0;
        else        smi_q <= pending;
    end

    assign smi_o = smi_q;

    AST_SMI_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(st_i & en_i)) |=> smi_o); // R10
    AST_SMI_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(st_i & en_i)) |=> !smi_o); // R10
endmodule

// File: rtl/usb_smi_evt_reg.sv
// Module: usb_smi_evt_reg (top)
// Status/enable register for USB host controller SMI events. Status flags
// sit at bit 16+i, enables at bit i, unused bits read 0. Reset only by the
// suspend-well reset rst_n; hc_reset_i is an ordinary event input.
// Assumes all inputs are synchronous to clk and NUM_PORTS <= 10.
module usb_smi_evt_reg
    import usb_smi_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [31:0]          wr_data_i,
    output logic [31:0]          rd_data_o,
    input  logic                 per_sched_en_i,
    input  logic                 cfg_flag_i,
    input  logic                 hc_halted_i,
    input  logic                 run_stop_i,
    input  logic                 hc_reset_i,
    input  logic                 async_evt_i,
    input  logic                 pm_chg_evt_i,
    input  logic [NUM_PORTS-1:0] port_own_chg_i,
    output logic                 smi_o
);
    localparam int unsigned NUM_EV = EV_PORT0 + NUM_PORTS;

    if (NUM_EV > STAT_OFS) begin : g_bad_cfg
        $error("usb_smi_evt_reg: NUM_PORTS too large for the register");
    end

    logic [MON_W-1:0]  mon;
    logic [MON_W-1:0]  mon_chg;
    logic [MON_W-1:0]  mon_rise;
    logic [NUM_EV-1:0] ev_set;
    logic [NUM_EV-1:0] ev_clr;
    logic [NUM_EV-1:0] status;
    logic [NUM_EV-1:0] enable_q;

    // Gather monitored levels into the detector vector.
    always_comb begin
        mon           = '0;
        mon[MON_PER]  = per_sched_en_i;
        mon[MON_CF]   = cfg_flag_i;
        mon[MON_HALT] = hc_halted_i;
        mon[MON_RST]  = hc_reset_i;
    end

    usb_smi_edge_det #(.W(MON_W)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (mon),
        .chg_o  (mon_chg),
        .rise_o (mon_rise)
    );

    // Map detected transitions and pulses onto event set requests.
    always_comb begin
        ev_set           = '0;
        ev_set[EV_HALT]  = mon_rise[MON_HALT] & ~run_stop_i;
        ev_set[EV_HCRST] = mon_rise[MON_RST];
        ev_set[EV_PER]   = mon_chg[MON_PER];
        ev_set[EV_CF]    = mon_chg[MON_CF];
        ev_set[EV_ASYNC] = async_evt_i;
        ev_set[EV_PM]    = pm_chg_evt_i;
        ev_set[EV_PORT0 +: NUM_PORTS] = port_own_chg_i;
    end

    // Write-one-to-clear requests from the status half of a write.
    always_comb ev_clr = wr_en_i ? wr_data_i[STAT_OFS +: NUM_EV] : '0;

    usb_smi_evt_bank #(.N(NUM_EV)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ev_set),
        .clr_i (ev_clr),
        .st_o  (status)
    );

    // Plain read/write enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)       enable_q <= '0;
        else if (wr_en_i) enable_q <= wr_data_i[NUM_EV-1:0];
    end

    usb_smi_irq #(.N(NUM_EV)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .st_i  (status),
        .en_i  (enable_q),
        .smi_o (smi_o)
    );

    // Assemble read data; unimplemented positions read as zero.
    always_comb begin
        rd_data_o = '0;
        rd_data_o[NUM_EV-1:0]          = enable_q;
        rd_data_o[STAT_OFS +: NUM_EV]  = status;
    end

    if (NUM_EV < STAT_OFS) begin : g_rsv
        localparam int unsigned RSV_W = STAT_OFS - NUM_EV;
        logic unused_wr_bits;
        // Reserved write bits have no storage.
        assign unused_wr_bits = ^{wr_data_i[STAT_OFS-1:NUM_EV],
                                  wr_data_i[REG_W-1:STAT_OFS+NUM_EV]};

        AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data_o[STAT_OFS-1:NUM_EV] == RSV_W'(0)) &&
            (rd_data_o[REG_W-1:STAT_OFS+NUM_EV] == RSV_W'(0))); // R9
    end

    AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[EV_HALT]) |-> !$past(run_stop_i)); // R4
    AST_RESET_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(enable_q)); // R5
endmodule

// File: tb/usb_smi_evt_reg_tb.sv
// Bench: directed corner cases then seeded random traffic, compared with
// a requirement-level model of the register kept in the bench.
module usb_smi_evt_reg_tb;
    localparam int NP = 4;
    localparam int NE = 6 + NP;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic          per = 1'b0, cf = 1'b0, halted = 1'b0, rs = 1'b0, hcr = 1'b0;
    logic          async_e = 1'b0, pm_e = 1'b0;
    logic [NP-1:0] port_e = '0;
    logic          smi;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // model state
    logic [NE-1:0] m_st = '0, m_en = '0;
    logic          m_smi = 1'b0, m_primed = 1'b0;
    logic [3:0]    m_prev = '0;

    always #2.5 clk = ~clk;

    usb_smi_evt_reg #(.NUM_PORTS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .per_sched_en_i(per), .cfg_flag_i(cf),
        .hc_halted_i(halted), .run_stop_i(rs), .hc_reset_i(hcr),
        .async_evt_i(async_e), .pm_chg_evt_i(pm_e), .port_own_chg_i(port_e),
        .smi_o(smi)
    );

    function automatic logic [31:0] model_rd();
        logic [31:0] r = '0;
        r[NE-1:0] = m_en;
        r[16 +: NE] = m_st;
        return r;
    endfunction

    function automatic logic [NE-1:0] model_events();
        logic [NE-1:0] e = '0;
        if (m_primed) begin
            e[0] = halted & ~m_prev[2] & ~rs;
            e[1] = hcr & ~m_prev[3];
            e[2] = per ^ m_prev[0];
            e[3] = cf ^ m_prev[1];
        end
        e[4] = async_e;
        e[5] = pm_e;
        e[6 +: NP] = port_e;
        return e;
    endfunction

    // advance one clock, updating the model from the driven inputs
    task automatic step();
        logic [NE-1:0] clr;
        if (!rst_n) begin
            m_st = '0; m_en = '0; m_smi = 0; m_primed = 0; m_prev = '0;
        end else begin
            clr = wr_en ? wr_data[16 +: NE] : '0;
            m_smi = |(m_st & m_en);
            m_st = (m_st & ~clr) | model_events();
            if (wr_en) m_en = wr_data[NE-1:0];
            m_prev = {hcr, halted, cf, per};
            m_primed = 1;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic chk_model(input string tag);
        chk(tag, rd_data, model_rd());
        chk(tag, {31'b0, smi}, {31'b0, m_smi});
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1; wr_data = d; step(); wr_en = 0; wr_data = '0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        // R1 / R11: lines high across reset release
        per = 1; cf = 1; hcr = 1;
        step(); step();
        chk("R1 reset read", rd_data, 32'h0);
        chk("R1 reset smi", {31'b0, smi}, 32'h0);
        rst_n = 1;
        step(); step();
        chk("R11 no event after release", rd_data, 32'h0);
        hcr = 0; step(); chk_model("R5 fall no event");
        chk("R5 fall no event", rd_data, 32'h0);

        // R2 periodic both directions
        per = 0; step();
        chk("R2 fall sets bit18", rd_data, 32'h0004_0000);
        wr(32'h0004_0000);
        chk("R7 w1c clears", rd_data, 32'h0);
        per = 1; step();
        chk("R2 rise sets bit18", rd_data, 32'h0004_0000);
        wr(32'h0000_0000);
        chk("R7 write zero keeps", rd_data, 32'h0004_0000);
        wr(32'h0004_0000);

        // R3 configure flag both directions
        cf = 0; step();
        chk("R3 fall sets bit19", rd_data, 32'h0008_0000);
        wr(32'h0008_0000);
        cf = 1; step();
        chk("R3 rise sets bit19", rd_data, 32'h0008_0000);
        wr(32'h0008_0000);

        // R4 halt cause
        rs = 1; step();
        halted = 1; step();
        chk("R4 halt with run set", rd_data, 32'h0);
        halted = 0; step();
        rs = 0; halted = 1; step();
        chk("R4 halt from run clear", rd_data, 32'h0001_0000);
        wr(32'h0001_0000);
        halted = 0; step();

        // R5 controller reset: edge only, enables kept
        wr(32'h0000_0155);
        hcr = 1; step();
        chk("R5 reset edge keeps enables", rd_data, 32'h0002_0155);
        wr(32'h0002_0155);
        step();
        chk("R5 held high no re-set", rd_data & 32'hFFFF_0000, 32'h0);
        hcr = 0; wr(32'h0);

        // R6 pulse events
        async_e = 1; step(); async_e = 0;
        chk("R6 async bit20", rd_data, 32'h0010_0000);
        pm_e = 1; step(); pm_e = 0;
        chk("R6 pm bit21", rd_data, 32'h0030_0000);
        port_e = 4'b1001; step(); port_e = '0;
        chk("R6 ports bit22 bit25", rd_data, 32'h0270_0000);
        wr(32'hFFFF_0000);
        chk("R7 clear all", rd_data, 32'h0);

        // R8 set beats clear
        async_e = 1; wr_en = 1; wr_data = 32'h0010_0000; step();
        wr_en = 0; wr_data = '0; async_e = 0;
        chk("R8 set wins", rd_data, 32'h0010_0000);
        wr(32'h0010_0000);

        // R9 reserved bits
        wr(32'hFFFF_FFFF);
        chk("R9 reserved zero", rd_data & 32'hFC00_FC00, 32'h0);
        chk("R7 enables written", rd_data, 32'h0000_03FF);
        wr(32'h0);

        // R10 smi timing
        pm_e = 1; step(); pm_e = 0; step();
        chk("R10 no smi when disabled", {31'b0, smi}, 32'h0);
        wr(32'h0000_0020);
        chk("R10 smi one cycle after enable", {31'b0, smi}, 32'h0);
        step();
        chk("R10 smi raised", {31'b0, smi}, 32'h1);
        wr(32'h0020_0020);
        chk("R10 smi still high", {31'b0, smi}, 32'h1);
        step();
        chk("R10 smi dropped", {31'b0, smi}, 32'h0);
        chk_model("R10 model agree");

        // random traffic, fixed seed
        void'($urandom(32'h5A17));
        for (int i = 0; i < 3000; i++) begin
            per     = ($urandom % 4 == 0) ? ~per : per;
            cf      = ($urandom % 5 == 0) ? ~cf : cf;
            rs      = ($urandom % 3 == 0) ? ~rs : rs;
            halted  = ($urandom % 4 == 0) ? ~halted : halted;
            hcr     = ($urandom % 6 == 0) ? ~hcr : hcr;
            async_e = ($urandom % 8 == 0);
            pm_e    = ($urandom % 8 == 0);
            port_e  = ($urandom % 6 == 0) ? NP'($urandom) : '0;
            wr_en   = ($urandom % 4 == 0);
            wr_data = $urandom;
            step();
            chk_model("RAND model");
        end
        wr_en = 0;

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule